// File: doc/BRIEF.md
# Peripheral Select Generator

This block drives a set of active-low peripheral select lines for a serial master. A small configuration register holds a select field, a decode-mode bit and a force bit. From these, plus a busy flag from the shift engine, it produces registered select outputs.

In direct mode each output line belongs to one peripheral. The block drives at most one line low. In decode mode the field is a binary peripheral index meant for an external decoder, and it appears on the outputs unchanged.

With force set, the outputs follow the field continuously. With force clear, the select is presented only while the shift engine reports busy, and all lines return high when it is idle.

Top module: `cs_select_gen`

## Requirements
- R1: While rst_ni is low and after its release, cs_n_o is all ones. The stored field resets to all ones, the force bit resets to set, and the decode bit resets to clear.
- R2: On a clock edge with cfg_we_i high, the register loads cfg_i. Within cfg_i, bit 9 is the decode bit, bits 13:10 are the select field and bit 14 is the force bit. While cfg_we_i is low, the stored configuration does not change.
- R3: In direct mode (decode bit 0), field bit k low selects peripheral k. cs_n_o then has only bit k low, and a field of all ones gives all ones.
- R4: In direct mode, a field with several zero bits selects the lowest-index zero only. The output never has more than one bit low.
- R5: In decode mode (decode bit 1), cs_n_o equals the stored field bit for bit whenever the select is presented.
- R6: With the force bit set, the select is presented whatever the value of busy_i.
- R7: With the force bit clear, the select is presented only while busy_i is high. Otherwise cs_n_o is all ones.
- R8: cs_n_o is registered. It reflects the stored configuration and busy_i one clock edge after they are sampled, so a configuration write shows on the outputs two edges after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_i | input | 6 | Configuration bits 14:9: force, field[3:0], decode |
| busy_i | input | 1 | Shift engine transfer in progress |
| cs_n_o | output | 4 | Active-low peripheral select lines |

## Verification
The bench builds the block with its default parameters: four select lines and the decode bit at position 9, which places the field at 13:10 and force at 14. With four lines, every selection in both modes can be tried directly. This includes fields with several zeros, which expose the lowest-index priority rule. The busy/force combinations and the two-edge write latency are also checked at the ports.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {CS_DIRECT = 1'b0, CS_DECODE = 1'b1} cs_mode_e;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg #(
  parameter int unsigned NUM_CS  = 4,
  parameter int unsigned DEC_BIT = 9,
  localparam int unsigned FLD_LO  = DEC_BIT + 1,
  localparam int unsigned FRC_BIT = DEC_BIT + NUM_CS + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [FRC_BIT:DEC_BIT] cfg_i,
  output logic [NUM_CS-1:0]      field_o,
  output cs_pkg::cs_mode_e       mode_o,
  output logic                   force_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_o <= '1;
      mode_o  <= cs_pkg::CS_DIRECT;
      force_o <= 1'b1;
    end else if (we_i) begin
      field_o <= cfg_i[FRC_BIT-1:FLD_LO];
      mode_o  <= cs_pkg::cs_mode_e'(cfg_i[DEC_BIT]);
      force_o <= cfg_i[FRC_BIT];
    end
  end
endmodule

// File: rtl/cs_encode.sv
module cs_encode #(
  parameter int unsigned NUM_CS = 4
) (
  input  logic [NUM_CS-1:0] field_i,
  input  cs_pkg::cs_mode_e  mode_i,
  output logic [NUM_CS-1:0] code_o
);
  logic [NUM_CS-1:0] onehot_n;
  logic [NUM_CS:0]   seen;

  // lowest-index zero wins in direct mode
  assign seen[0] = 1'b0;
  for (genvar k = 0; k < NUM_CS; k++) begin : g_pri
    assign onehot_n[k] = field_i[k] | seen[k];
    assign seen[k+1]   = seen[k] | ~field_i[k];
  end

  always_comb begin
    if (mode_i == cs_pkg::CS_DECODE) code_o = field_i;
    else                             code_o = onehot_n;
  end
endmodule

// File: rtl/cs_select_gen.sv
module cs_select_gen #(
  parameter int unsigned NUM_CS  = 4,
  parameter int unsigned DEC_BIT = 9,
  localparam int unsigned FRC_BIT = DEC_BIT + NUM_CS + 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_we_i,
  input  logic [FRC_BIT:DEC_BIT] cfg_i,
  input  logic                   busy_i,
  output logic [NUM_CS-1:0]      cs_n_o
);
  logic [NUM_CS-1:0] cfg_field;
  cs_pkg::cs_mode_e  cfg_mode;
  logic              cfg_force;
  logic [NUM_CS-1:0] sel_code;

  cs_cfg_reg #(.NUM_CS(NUM_CS), .DEC_BIT(DEC_BIT)) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .cfg_i   (cfg_i),
    .field_o (cfg_field),
    .mode_o  (cfg_mode),
    .force_o (cfg_force)
  );

  cs_encode #(.NUM_CS(NUM_CS)) u_enc (
    .field_i (cfg_field),
    .mode_i  (cfg_mode),
    .code_o  (sel_code)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cs_n_o <= '1;
    else if (cfg_force || busy_i) cs_n_o <= sel_code;
    else                          cs_n_o <= '1;
  end
endmodule

// File: rtl/cs_select_chk.sv
module cs_select_chk #(
  parameter int unsigned NUM_CS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              busy_i,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic [NUM_CS-1:0] cfg_field,
  input logic              cfg_force,
  input logic              cfg_dec
);
  p_idle_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_force && !busy_i) |=> (cs_n_o == '1));

  p_one_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_dec |=> ($countones(~cs_n_o) <= 1));

  p_decode_pass_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_dec && (cfg_force || busy_i)) |=> (cs_n_o == $past(cfg_field)));

  p_cfg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> $stable(cfg_field));

  p_force_on_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_force && cfg_dec && !busy_i) |=> (cs_n_o == $past(cfg_field)));
endmodule

bind cs_select_gen cs_select_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_we_i  (cfg_we_i),
  .busy_i    (busy_i),
  .cs_n_o    (cs_n_o),
  .cfg_field (cfg_field),
  .cfg_force (cfg_force),
  .cfg_dec   (cfg_mode == cs_pkg::CS_DECODE)
);

// File: tb/sim_cs_select_gen.sv
module sim_cs_select_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [14:9] cfg_i = '0;
  logic       busy_i = 1'b0;
  logic [3:0] cs_n_o;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  cs_select_gen u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i),
    .cfg_i(cfg_i), .busy_i(busy_i), .cs_n_o(cs_n_o)
  );

  // {force, field[3:0], decode, busy, expected}
  localparam logic [10:0] VEC [9] = '{
    {1'b1, 4'b1110, 1'b0, 1'b0, 4'b1110},
    {1'b1, 4'b1011, 1'b0, 1'b0, 4'b1011},
    {1'b1, 4'b0101, 1'b0, 1'b0, 4'b1101},
    {1'b1, 4'b0101, 1'b1, 1'b0, 4'b0101},
    {1'b0, 4'b1110, 1'b0, 1'b0, 4'b1111},
    {1'b0, 4'b1110, 1'b0, 1'b1, 4'b1110},
    {1'b0, 4'b0011, 1'b1, 1'b1, 4'b0011},
    {1'b0, 4'b0011, 1'b1, 1'b0, 4'b1111},
    {1'b1, 4'b1111, 1'b0, 1'b1, 4'b1111}
  };
  localparam string VTAG [9] = '{"R3 R6", "R3", "R4", "R5", "R7",
                                 "R7 R3", "R5 R7", "R7", "R3"};

  task automatic check(input string tag, input logic [3:0] exp);
    total++;
    if (cs_n_o !== exp) begin
      bad++;
      $display("FAIL %s: cs_n_o=%b expected=%b", tag, cs_n_o, exp);
    end
  endtask

  task automatic write_cfg(input logic [5:0] c, input logic we);
    @(negedge clk_i);
    cfg_i = c; cfg_we_i = we;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  initial begin
    #25;
    check("R1 in reset", 4'b1111);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); check("R1 after release", 4'b1111);
    busy_i = 1'b1;
    @(negedge clk_i); check("R1 default field", 4'b1111);

    for (int i = 0; i < 9; i++) begin
      @(negedge clk_i);
      busy_i = VEC[i][4]; cfg_i = VEC[i][10:5]; cfg_we_i = 1'b1;
      @(negedge clk_i); cfg_we_i = 1'b0;
      @(negedge clk_i); check(VTAG[i], VEC[i][3:0]);
    end

    // R8: config write latency is two edges
    busy_i = 1'b0;
    write_cfg({1'b1, 4'b0111, 1'b0}, 1'b1);
    check("R8 one edge after write", 4'b1111);
    @(negedge clk_i); check("R8 two edges after write", 4'b0111);

    // R2: write without strobe is ignored
    write_cfg({1'b1, 4'b1110, 1'b1}, 1'b0);
    @(negedge clk_i); check("R2 no strobe", 4'b0111);

    // R8/R7: busy follows with one edge of latency
    write_cfg({1'b0, 4'b1101, 1'b0}, 1'b1);
    @(negedge clk_i); check("R7 idle", 4'b1111);
    busy_i = 1'b1;
    @(negedge clk_i); check("R8 busy rise", 4'b1101);
    busy_i = 1'b0;
    @(negedge clk_i); check("R8 busy fall", 4'b1111);

    // R4: all zeros in direct mode selects line 0 only
    write_cfg({1'b1, 4'b0000, 1'b0}, 1'b1);
    @(negedge clk_i); check("R4 all zero", 4'b1110);

    // R1: reset mid-run restores defaults
    rst_ni = 1'b0;
    @(negedge clk_i); check("R1 async reset", 4'b1111);
    rst_ni = 1'b1; busy_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i); check("R1 field ones", 4'b1111);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule